// File: doc/BRIEF.md
# Utilization-Driven Bus Frequency and Voltage Sequencer

This block picks the operating point of an on-chip bus. It has five levels, running at 266, 200, 160, 133 and 100 MHz. Index 0 is the fastest and index 4 the slowest. A free-running tick counter marks the end of each sample period. At that moment the block takes in a snapshot from every traffic monitor: a data-beat count, a cycle count and an overflow flag.

It turns the snapshot into a percentage utilization, using a serial divider that is shared by all monitors. It then chooses a new level and drives two request/acknowledge handshakes, one to the supply regulator and one to the clock switch. The order of the two steps depends on the direction of the change, so the supply always supports the clock in use.

A suspend input overrides the choice. It moves the bus to the fastest level, raising the supply before the clock, and keeps it there until the input drops.

Top module: `bus_dvfs_seq`

## Requirements
- R1: After reset, `cur_level_o`, `volt_lvl_o` and `clk_lvl_o` all read level 2 (160 MHz), and both request outputs are low.
- R2: `sample_o` is high for one cycle out of every `SAMPLE_TICKS` cycles. The monitor inputs are captured on the clock edge that ends such a cycle.
- R3: The utilization of one monitor is floor(beats*100/cycles), or beats*100 when its cycle count is 0. The sample's utilization is the largest value over all monitors.
- R4: If any monitor's overflow bit is set at the capture edge, the whole sample is dropped. No request is made and the level stays unchanged.
- R5: A utilization above 25 selects level 0.
- R6: A utilization of 24 or 25 (above 25-2) keeps the current level.
- R7: For a utilization of 23 or less, the target is the current frequency times the utilization divided by 24. The level chosen is the slowest one whose frequency is at least that target.
- R8: When moving to a faster level (smaller index), the voltage request and its acknowledge complete before the clock request is raised.
- R9: When moving to a slower level (larger index), the clock request and its acknowledge complete before the voltage request is raised.
- R10: When the chosen level equals the current one, no request is made. `cur_level_o` changes only in the cycle after the acknowledge that completes a change.
- R11: At most one request is high at a time. A request stays high, with its level stable, until its acknowledge arrives. A sample that falls while a change is in progress is ignored.
- R12: While `suspend_i` is high, the block moves to level 0 (voltage first, then clock) and ignores samples. Scaling resumes with the first sample taken after `suspend_i` falls.
- R13: `volt_lvl_o` is never greater than `clk_lvl_o`, so the requested supply always supports the requested clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_beats_i | input | NMON*CNT_W | Per-monitor read+write beat counts, monitor 0 in the low bits |
| mon_cycles_i | input | NMON*CNT_W | Per-monitor cycle counts, monitor 0 in the low bits |
| mon_ovf_i | input | NMON | Per-monitor cycle-counter overflow flags |
| suspend_i | input | 1 | Force fastest level and freeze scaling while high |
| volt_ack_i | input | 1 | Regulator finished the requested voltage |
| clk_ack_i | input | 1 | Clock switch finished the requested frequency |
| sample_o | output | 1 | High in the cycle whose closing edge captures a sample |
| volt_req_o | output | 1 | Voltage change requested |
| volt_lvl_o | output | 3 | Level whose voltage is requested or applied |
| clk_req_o | output | 1 | Clock change requested |
| clk_lvl_o | output | 3 | Level whose frequency is requested or applied |
| cur_level_o | output | 3 | Level in effect after the last completed change |

## Verification
A wrong quotient, a lost maximum or a bad threshold compare produces a wrong level. That level appears on `cur_level_o`, `volt_lvl_o` and `clk_lvl_o` before the next sample edge. The bench sweeps every starting level against a fine grid of utilizations, so such an error surfaces within one sample period. A faulty sequencing state shows up in the order of the two handshakes, or as a voltage index above the clock index. It can also show as a request that is issued for an unchanged level or for an overflowed sample, and it is visible at the acknowledge where it happens.

// File: rtl/bus_dvfs_seq.sv
module bus_dvfs_seq #(
  parameter int SAMPLE_TICKS = 10_000_000,
  parameter int NMON         = 2,
  parameter int CNT_W        = 16,
  parameter int UP_PCT       = 25,
  parameter int DOWN_DIFF    = 2,
  parameter int RESET_LVL    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NMON*CNT_W-1:0]   mon_beats_i,
  input  logic [NMON*CNT_W-1:0]   mon_cycles_i,
  input  logic [NMON-1:0]         mon_ovf_i,
  input  logic                    suspend_i,
  input  logic                    volt_ack_i,
  input  logic                    clk_ack_i,
  output logic                    sample_o,
  output logic                    volt_req_o,
  output logic [2:0]              volt_lvl_o,
  output logic                    clk_req_o,
  output logic [2:0]              clk_lvl_o,
  output logic [2:0]              cur_level_o
);

  localparam int NLVL     = 5;
  localparam int UW       = CNT_W + 7;
  localparam int TW       = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam int MW       = (NMON > 1) ? $clog2(NMON) : 1;
  localparam int BCW      = $clog2(UW);
  localparam int HOLD_PCT = UP_PCT - DOWN_DIFF;
  localparam int SCALE    = 2 * UP_PCT - DOWN_DIFF;
  localparam int PW       = UW + 20;

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_PICK, S_VFIRST, S_CLK, S_VLAST} st_t;

  function automatic logic [9:0] lvl_mhz(input logic [2:0] l);
    case (l)
      3'd0:    return 10'd266;
      3'd1:    return 10'd200;
      3'd2:    return 10'd160;
      3'd3:    return 10'd133;
      default: return 10'd100;
    endcase
  endfunction

  function automatic logic [UW-1:0] scaled(input logic [CNT_W-1:0] b);
    return UW'(b) * UW'(100);
  endfunction

  function automatic logic [2:0] pick(input logic [2:0] c, input logic [UW-1:0] u);
    logic [PW-1:0] need;
    logic [2:0]    sel;
    need = PW'(lvl_mhz(c)) * PW'(u) * PW'(2);
    sel  = 3'd0;
    for (int k = 0; k < NLVL; k++)
      if (PW'(lvl_mhz(3'(k))) * PW'(SCALE) >= need) sel = 3'(k);
    return sel;
  endfunction

  st_t                   st;
  logic [TW-1:0]         tmr;
  logic [NMON*CNT_W-1:0] beats_q, cyc_q;
  logic [MW-1:0]         mon;
  logic [BCW-1:0]        bitc;
  logic [UW-1:0]         num, quo, umax;
  logic [CNT_W-1:0]      rem;
  logic [2:0]            cur, tgt, vlvl, clvl;
  logic                  vreq, creq, up;

  assign sample_o    = (tmr == TW'(SAMPLE_TICKS - 1));
  assign volt_req_o  = vreq;
  assign clk_req_o   = creq;
  assign volt_lvl_o  = vlvl;
  assign clk_lvl_o   = clvl;
  assign cur_level_o = cur;

  wire [CNT_W-1:0] dvs      = cyc_q[mon*CNT_W +: CNT_W];
  wire [CNT_W:0]   trial    = {rem, num[UW-1]};
  wire             fits     = trial >= {1'b0, dvs};
  wire [UW-1:0]    qnext    = {quo[UW-2:0], fits};
  wire             mon_done = (dvs == '0) || (bitc == BCW'(UW - 1));
  wire [UW-1:0]    mon_util = (dvs == '0) ? num : qnext;
  wire             last_mon = (mon == MW'(NMON - 1));
  wire [MW-1:0]    mon_n    = mon + 1'b1;
  wire [2:0]       choice   = (umax > UW'(UP_PCT))   ? 3'd0 :
                              (umax > UW'(HOLD_PCT)) ? cur  : pick(cur, umax);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; beats_q <= '0; cyc_q <= '0; mon <= '0; bitc <= '0;
      num <= '0; quo <= '0; umax <= '0; rem <= '0;
      cur <= 3'(RESET_LVL); tgt <= 3'(RESET_LVL); vlvl <= 3'(RESET_LVL); clvl <= 3'(RESET_LVL);
      vreq <= 1'b0; creq <= 1'b0; up <= 1'b0;
    end else begin
      tmr <= sample_o ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: begin
          if (suspend_i) begin
            if (cur != 3'd0) begin
              tgt <= 3'd0; up <= 1'b1; vlvl <= 3'd0; vreq <= 1'b1; st <= S_VFIRST;
            end
          end else if (sample_o && !(|mon_ovf_i)) begin
            beats_q <= mon_beats_i; cyc_q <= mon_cycles_i;
            num <= scaled(mon_beats_i[CNT_W-1:0]);
            mon <= '0; bitc <= '0; rem <= '0; quo <= '0; umax <= '0;
            st <= S_DIV;
          end
        end
        S_DIV: begin
          rem  <= fits ? CNT_W'(trial - {1'b0, dvs}) : trial[CNT_W-1:0];
          num  <= num << 1;
          quo  <= qnext;
          bitc <= bitc + 1'b1;
          if (mon_done) begin
            if (mon_util > umax) umax <= mon_util;
            bitc <= '0; rem <= '0; quo <= '0;
            if (last_mon) st <= S_PICK;
            else begin
              mon <= mon_n;
              num <= scaled(beats_q[mon_n*CNT_W +: CNT_W]);
            end
          end
        end
        S_PICK: begin
          tgt <= choice;
          if (choice == cur) st <= S_IDLE;
          else if (choice < cur) begin
            up <= 1'b1; vlvl <= choice; vreq <= 1'b1; st <= S_VFIRST;
          end else begin
            up <= 1'b0; clvl <= choice; creq <= 1'b1; st <= S_CLK;
          end
        end
        S_VFIRST: if (volt_ack_i) begin
          vreq <= 1'b0; clvl <= tgt; creq <= 1'b1; st <= S_CLK;
        end
        S_CLK: if (clk_ack_i) begin
          creq <= 1'b0;
          if (up) begin cur <= tgt; st <= S_IDLE; end
          else begin vlvl <= tgt; vreq <= 1'b1; st <= S_VLAST; end
        end
        S_VLAST: if (volt_ack_i) begin
          vreq <= 1'b0; cur <= tgt; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] gap;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gap <= '0;
    else gap <= sample_o ? '0 : gap + 1'b1;

  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> gap == (TW+1)'(SAMPLE_TICKS - 1));

  p_drop_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && sample_o && !suspend_i && (|mon_ovf_i)) |=> (st == S_IDLE && !vreq && !creq));

  p_move_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level_o) |-> $past(volt_ack_i || clk_ack_i));

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(volt_req_o && clk_req_o));

  p_vreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req_o && !volt_ack_i) |=> (volt_req_o && $stable(volt_lvl_o)));

  p_creq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req_o && !clk_ack_i) |=> (clk_req_o && $stable(clk_lvl_o)));

  p_supply_safe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    volt_lvl_o <= clk_lvl_o);

  p_suspend_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_i && cur_level_o == 3'd0 && !volt_req_o && !clk_req_o && st == S_IDLE) |=> (!volt_req_o && !clk_req_o));

endmodule

// File: tb/bus_dvfs_seq_test.sv
module bus_dvfs_seq_test;
  localparam int CLK_P = 10;
  localparam int TICKS = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] beats, cycs;
  logic [1:0]  ovf;
  logic susp, vack, cack;
  logic sample_o, volt_req_o, clk_req_o;
  logic [2:0] volt_lvl_o, clk_lvl_o, cur_level_o;

  bus_dvfs_seq #(.SAMPLE_TICKS(TICKS), .NMON(2), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .mon_beats_i(beats), .mon_cycles_i(cycs), .mon_ovf_i(ovf),
    .suspend_i(susp), .volt_ack_i(vack), .clk_ack_i(cack), .sample_o(sample_o),
    .volt_req_o(volt_req_o), .volt_lvl_o(volt_lvl_o), .clk_req_o(clk_req_o),
    .clk_lvl_o(clk_lvl_o), .cur_level_o(cur_level_o));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int ack_dly = 3;
  int nev = 0;
  int ev[4];
  int cur_m = 2, exp_lvl = 2, exp_kind = 0;
  bit have_prev = 0;
  string prev_tag = "";

  initial begin
    int vc, cc;
    vc = 0; cc = 0; vack = 1'b0; cack = 1'b0;
    forever begin
      @(negedge clk);
      vack = 1'b0; cack = 1'b0;
      if (volt_req_o) begin
        vc++;
        if (vc >= ack_dly) begin vack = 1'b1; vc = 0; if (nev < 4) ev[nev] = 1; nev++; end
      end
      if (clk_req_o) begin
        cc++;
        if (cc >= ack_dly) begin cack = 1'b1; cc = 0; if (nev < 4) ev[nev] = 2; nev++; end
      end
    end
  end

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic int ref_util(int b, int c);
    return (c == 0) ? b * 100 : (b * 100) / c;
  endfunction

  function automatic int ref_next(int c, int u);
    int f[5] = '{266, 200, 160, 133, 100};
    real t;
    if (u > 25) return 0;
    if (u > 23) return c;
    t = real'(f[c] * u) / 24.0;
    for (int k = 4; k >= 0; k--) if (real'(f[k]) >= t) return k;
    return 0;
  endfunction

  task automatic wait_sample();
    do @(negedge clk); while (!sample_o);
  endtask

  task automatic check_prev();
    bit ok;
    if (!have_prev) return;
    ok = (cur_level_o == 3'(exp_lvl)) && (volt_lvl_o == 3'(exp_lvl)) && (clk_lvl_o == 3'(exp_lvl))
         && !volt_req_o && !clk_req_o;
    if (exp_kind == 0) ok = ok && (nev == 0);
    if (exp_kind == 1) ok = ok && (nev == 2) && ev[0] == 1 && ev[1] == 2;
    if (exp_kind == 2) ok = ok && (nev == 2) && ev[0] == 2 && ev[1] == 1;
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual level=%0d volt=%0d clk=%0d events=%0d first=%0d expected level=%0d order=%0d",
               prev_tag, cur_level_o, volt_lvl_o, clk_lvl_o, nev, ev[0], exp_lvl, exp_kind);
    end
  endtask

  task automatic apply_raw(int b0, int c0, int b1, int c1, logic [1:0] o, logic s, string tag);
    int u, n;
    wait_sample();
    check_prev();
    beats = {16'(b1), 16'(b0)};
    cycs  = {16'(c1), 16'(c0)};
    ovf = o; susp = s;
    u = ref_util(b0, c0);
    if (ref_util(b1, c1) > u) u = ref_util(b1, c1);
    if (s) n = 0;
    else if (|o) n = cur_m;
    else n = ref_next(cur_m, u);
    exp_kind = (n < cur_m) ? 1 : (n > cur_m) ? 2 : 0;
    exp_lvl = n; cur_m = n; nev = 0; have_prev = 1; prev_tag = tag;
  endtask

  task automatic apply(int u, int pat, string tag);
    case (pat % 3)
      0: apply_raw(u, 100, 0, 50, 2'b00, 1'b0, tag);
      1: apply_raw(u / 2, 100, u * 7 + 3, 700, 2'b00, 1'b0, tag);
      default: apply_raw(u * 3, 300, u, 101, 2'b00, 1'b0, tag);
    endcase
  endtask

  function automatic string cat(int u, int c);
    string s;
    int n;
    n = ref_next(c, u);
    s = (u > 25) ? "R5" : (u > 23) ? "R6" : "R7";
    if (n < c) s = {s, "/R8"};
    else if (n > c) s = {s, "/R9"};
    else s = {s, "/R10"};
    return s;
  endfunction

  initial begin
    int ulist[15] = '{0, 5, 10, 15, 17, 18, 19, 20, 21, 22, 23, 24, 25, 26, 40};
    int chain[4]  = '{18, 19, 16, 18};
    int cnt, old;
    beats = {16'd0, 16'd24}; cycs = {16'd50, 16'd100}; ovf = 2'b00; susp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (cur_level_o !== 3'd2 || volt_lvl_o !== 3'd2 || clk_lvl_o !== 3'd2 || volt_req_o || clk_req_o) begin
      n_fail++;
      $display("FAIL R1: actual level=%0d volt=%0d clk=%0d reqs=%b%b expected 2/2/2/00",
               cur_level_o, volt_lvl_o, clk_lvl_o, volt_req_o, clk_req_o);
    end

    wait_sample();
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!sample_o);
    n_chk++;
    if (cnt != TICKS) begin
      n_fail++;
      $display("FAIL R2: actual period=%0d expected=%0d", cnt, TICKS);
    end

    apply_raw(12, 100, 0, 0, 2'b01, 1'b0, "R4 ovf mon0");
    apply_raw(12, 100, 3, 100, 2'b10, 1'b0, "R4 ovf mon1");
    apply_raw(1, 0, 0, 100, 2'b00, 1'b0, "R3 zero cycles");
    apply_raw(0, 0, 0, 0, 2'b00, 1'b0, "R3 all zero");
    apply_raw(5, 100, 30, 100, 2'b00, 1'b0, "R3 max of monitors");
    apply_raw(99, 1000, 9, 1000, 2'b00, 1'b0, "R3 floor");

    for (int s = 0; s < 5; s++)
      for (int i = 0; i < 15; i++) begin
        apply(40, i, "R5 to top");
        for (int k = 0; k < s; k++) apply(chain[k], i + k, "R7 chain");
        apply(ulist[i], i + s, cat(ulist[i], cur_m));
      end

    for (int k = 0; k < 3; k++) apply(chain[k], k, "R7 chain");
    apply(5, 0, "R12 enter");
    apply_raw(5, 100, 0, 50, 2'b00, 1'b1, "R12 enter");
    apply_raw(5, 100, 0, 50, 2'b00, 1'b1, "R12 frozen");
    apply_raw(5, 100, 0, 50, 2'b00, 1'b0, "R12 resume");
    apply_raw(5, 100, 0, 50, 2'b00, 1'b1, "R12 re-enter");
    apply_raw(5, 100, 0, 50, 2'b00, 1'b0, "R12 resume");

    apply(40, 0, "R5 top");
    apply(40, 1, "R10 hold top");
    ack_dly = 60;
    old = 0;
    apply(10, 2, "R9 slow acks");
    wait_sample();
    n_chk++;
    if (cur_level_o !== 3'(old) || !(volt_req_o || clk_req_o)) begin
      n_fail++;
      $display("FAIL R11: actual level=%0d busy=%b expected level=%0d busy=1",
               cur_level_o, volt_req_o | clk_req_o, old);
    end
    beats = {16'd0, 16'd40}; cycs = {16'd50, 16'd100};
    apply(40, 0, "R11 busy sample ignored");
    ack_dly = 3;
    apply(40, 1, "R10 hold top");

    wait_sample();
    check_prev();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule